// File: doc/BRIEF.md
# Low-Latency Transposed FIR Equalizer

This block is a programmable FIR equalizer for a high-rate sampled data path, such as a read channel. Each clock cycle one signed input sample is broadcast to every tap at the same time. Each tap multiplies that sample by its own coefficient and adds the product to the partial sum arriving from the next higher tap. The running sum stays in redundant carry-save form, as a sum vector and a carry vector. Nothing is resolved inside the chain, so one tap costs a multiplier plus a few 3:2 compressor levels.

The tap-0 pair is registered and then resolved by a single ripple-carry merge adder. Its result is registered as the output word, which gives a fixed two-cycle latency. Each multiplier recodes its coefficient with radix-4 Booth digits, so a 6-bit coefficient yields three partial products. The number of taps, the sample, coefficient and output widths, and the choice between wrap and saturation are all parameters.

Top module: `tcs_fir_eq`

## Requirements
- R1: With the default parameters (8 taps, 6-bit samples, 6-bit coefficients, 12-bit output), coefficient k occupies bits `coef[k*CW +: CW]`. Samples and coefficients are two's complement, and the full-precision result is y[n] = sum over k of c_k * x[n-k].
- R2: A sample present on `in_smp` before clock edge E is captured at E and first affects `out_smp` after edge E+1, which is two cycles of latency. The filter shifts on every clock, whatever the state of `in_vld`.
- R3: `out_vld` equals `in_vld` delayed by two clock edges.
- R4: A synchronous active-high `rst` clears all tap sum and carry vectors, the output word and the valid pipeline to zero, including in the middle of a stream.
- R5: With `SATURATE = 0`, `out_smp` is the low OW bits of the full-precision sum.
- R6: With `SATURATE = 1`, `out_smp` is the full-precision sum clamped to the range [-2^(OW-1), 2^(OW-1)-1].
- R7: Extreme operands are exact. These are coefficients of -32 and +31 with samples of -32, which give per-tap products of 1024 and -992.
- R8: A coefficient change applies to the sample captured in the same cycle and to later ones. Partial sums already in the chain keep the coefficients that were present when their samples were captured.
- R9: After NT+2 consecutive zero samples, `out_smp` is zero.
- R10: After NT+2 consecutive cycles with every coefficient at zero, `out_smp` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid strobe |
| in_smp | input | DW | Two's complement input sample, broadcast to all taps |
| coef | input | NT*CW | Packed coefficients; tap k at bits [k*CW +: CW] |
| out_vld | output | 1 | Input valid delayed by two cycles |
| out_smp | output | OW | Filtered output, wrapped or saturated |

## Verification
The hard case is a coefficient update landing in the same cycle as a new sample capture while older partial sums are still in flight in the carry-save chain. The bench provokes it by switching the whole coefficient vector every third sample under pseudo-random data. A scoreboard keeps a coefficient snapshot per sample, so each expected output uses the coefficients that were live when each contributing sample entered. A second collision is a reset arriving mid-stream, which must discard in-flight partial sums in the same cycle as a capture would occur. It is judged at the ports on a wrapping instance and a saturating instance side by side.

// File: rtl/fir_eq_pkg.sv
package fir_eq_pkg;

    // Radix-4 Booth digit: magnitude select plus sign
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;

    // Recode a 3-bit overlapping window {b[2i+1], b[2i], b[2i-1]}
    function automatic booth_dig_t booth_recode(input logic [2:0] t);
        booth_dig_t r;
        r.neg = t[2] & ~(t[1] & t[0]);
        r.one = t[1] ^ t[0];
        r.two = (t == 3'b011) || (t == 3'b100);
        return r;
    endfunction

endpackage

// File: rtl/fir_eq_tap.sv
module fir_eq_tap
    import fir_eq_pkg::*;
#(
    parameter int DW = 6,
    parameter int CW = 6,
    parameter int AW = 15
) (
    input  logic [DW-1:0] x_i,
    input  logic [CW-1:0] coef_i,
    input  logic [AW-1:0] sum_i,
    input  logic [AW-1:0] car_i,
    output logic [AW-1:0] sum_o,
    output logic [AW-1:0] car_o
);
    localparam int NPP = (CW + 1) / 2;
    localparam int CWE = 2 * NPP;

    logic [CWE:0]  cx;
    logic [AW-1:0] xs;

    assign cx = {CWE'($signed(coef_i)), 1'b0};
    assign xs = AW'($signed(x_i));

    always_comb begin
        logic [AW-1:0] s, c, pp, mag, corr, ns;
        booth_dig_t    dg;
        s    = sum_i;
        c    = car_i;
        corr = '0;
        for (int i = 0; i < NPP; i++) begin
            dg  = booth_recode(cx[2*i+2 -: 3]);
            mag = dg.one ? xs : (dg.two ? (xs << 1) : '0);
            pp  = (dg.neg ? ~mag : mag) << (2 * i);
            corr[2*i] = dg.neg;
            ns = s ^ c ^ pp;
            c  = ((s & c) | (s & pp) | (c & pp)) << 1;
            s  = ns;
        end
        ns = s ^ c ^ corr;
        c  = ((s & c) | (s & corr) | (c & corr)) << 1;
        s  = ns;
        sum_o = s;
        car_o = c;
    end

endmodule

// File: rtl/fir_eq_merge.sv
module fir_eq_merge #(
    parameter int W = 15
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & cy[i]) | (b_i[i] & cy[i]);
        end
    end

endmodule

// File: rtl/tcs_fir_eq.sv
module tcs_fir_eq #(
    parameter int NT       = 8,
    parameter int DW       = 6,
    parameter int CW       = 6,
    parameter int OW       = 12,
    parameter bit SATURATE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [DW-1:0]      in_smp,
    input  logic [NT*CW-1:0]   coef,
    output logic               out_vld,
    output logic [OW-1:0]      out_smp
);
    localparam int AW = DW + CW + $clog2(NT);
    localparam int EW = (AW > OW) ? AW : OW;

    typedef struct packed {
        logic [NT-1:0][AW-1:0] sum;
        logic [NT-1:0][AW-1:0] car;
        logic [1:0]            vld;
        logic [OW-1:0]         y;
    } state_t;

    state_t q, d;

    logic [AW-1:0] tap_sum [NT];
    logic [AW-1:0] tap_car [NT];
    logic [AW-1:0] merged;
    logic [EW-1:0] ext;
    logic          ovf;

    for (genvar k = 0; k < NT; k++) begin : g_tap
        if (k == NT - 1) begin : g_end
            fir_eq_tap #(.DW(DW), .CW(CW), .AW(AW)) tap_i (
                .x_i    (in_smp),
                .coef_i (coef[k*CW +: CW]),
                .sum_i  ('0),
                .car_i  ('0),
                .sum_o  (tap_sum[k]),
                .car_o  (tap_car[k])
            );
        end else begin : g_mid
            fir_eq_tap #(.DW(DW), .CW(CW), .AW(AW)) tap_i (
                .x_i    (in_smp),
                .coef_i (coef[k*CW +: CW]),
                .sum_i  (q.sum[k+1]),
                .car_i  (q.car[k+1]),
                .sum_o  (tap_sum[k]),
                .car_o  (tap_car[k])
            );
        end
    end

    fir_eq_merge #(.W(AW)) merge_i (
        .a_i   (q.sum[0]),
        .b_i   (q.car[0]),
        .sum_o (merged)
    );

    always_comb begin
        d     = q;
        d.vld = {q.vld[0], in_vld};
        for (int k = 0; k < NT; k++) begin
            d.sum[k] = tap_sum[k];
            d.car[k] = tap_car[k];
        end
        ext = EW'($signed(merged));
        ovf = !((&ext[EW-1:OW-1]) || (~|ext[EW-1:OW-1]));
        if (SATURATE && ovf) begin
            d.y = {ext[EW-1], {(OW-1){~ext[EW-1]}}};
        end else begin
            d.y = ext[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_vld = q.vld[1];
    assign out_smp = q.y;

endmodule

// File: rtl/fir_eq_chk.sv
module fir_eq_chk #(
    parameter int NT = 8,
    parameter int DW = 6,
    parameter int CW = 6,
    parameter int OW = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [DW-1:0]    in_smp,
    input logic [NT*CW-1:0] coef,
    input logic             out_vld,
    input logic [OW-1:0]    out_smp
);
    localparam int CNW  = $clog2(NT + 3) + 1;
    localparam int LIMV = NT + 2;

    logic [1:0]     since_q;
    logic [CNW-1:0] zx_q, zc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            zx_q    <= '0;
            zc_q    <= '0;
        end else begin
            if (since_q != 2'd2) since_q <= since_q + 2'd1;
            if (in_smp != '0)                zx_q <= '0;
            else if (zx_q != CNW'(LIMV))     zx_q <= zx_q + 1'b1;
            if (coef != '0)                  zc_q <= '0;
            else if (zc_q != CNW'(LIMV))     zc_q <= zc_q + 1'b1;
        end
    end

    // R3
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    // R4
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_smp == '0));

    // R9
    zero_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (zx_q == CNW'(LIMV)) |-> (out_smp == '0));

    // R10
    zero_coef_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (zc_q == CNW'(LIMV)) |-> (out_smp == '0));

endmodule

bind tcs_fir_eq fir_eq_chk #(.NT(NT), .DW(DW), .CW(CW), .OW(OW)) chk_i (.*);

// File: tb/tcs_fir_eq_tb_top.sv
module tcs_fir_eq_tb_top;
    localparam int NT = 8;
    localparam int DW = 6;
    localparam int CW = 6;
    localparam int OW = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             in_vld = 1'b0;
    logic [DW-1:0]    in_smp = '0;
    logic [NT*CW-1:0] coef = '0;
    logic             vld_w, vld_s;
    logic [OW-1:0]    y_w, y_s;

    tcs_fir_eq #(.NT(NT), .DW(DW), .CW(CW), .OW(OW), .SATURATE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp), .coef(coef),
        .out_vld(vld_w), .out_smp(y_w));

    tcs_fir_eq #(.NT(NT), .DW(DW), .CW(CW), .OW(OW), .SATURATE(1'b1)) dut_sat_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp), .coef(coef),
        .out_vld(vld_s), .out_smp(y_s));

    typedef struct {
        int    full;
        bit    vld;
        string tag;
    } exp_t;

    exp_t             sbq[$];
    logic [DW-1:0]    xh [NT];
    logic [NT*CW-1:0] ch [NT];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int wrapv(input int v);
        int t;
        t = v & ((1 << OW) - 1);
        if (t >= (1 << (OW - 1))) t -= (1 << OW);
        return t;
    endfunction

    function automatic int clampv(input int v);
        if (v > (1 << (OW - 1)) - 1) return (1 << (OW - 1)) - 1;
        if (v < -(1 << (OW - 1)))    return -(1 << (OW - 1));
        return v;
    endfunction

    function automatic logic [NT*CW-1:0] pack_all(input int v);
        logic [NT*CW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(v);
        return r;
    endfunction

    function automatic logic [NT*CW-1:0] pack_a();
        int va [NT] = '{3, -5, 7, -2, 1, 31, -32, 4};
        logic [NT*CW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(va[k]);
        return r;
    endfunction

    function automatic logic [NT*CW-1:0] pack_b();
        int vb [NT] = '{-1, 9, -16, 12, -7, 2, 15, -9};
        logic [NT*CW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(vb[k]);
        return r;
    endfunction

    task automatic lfsr_next();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Driver: applies one sample and pushes its expected full-precision result
    task automatic step(input logic [DW-1:0] x, input bit v,
                        input logic [NT*CW-1:0] c, input string tag);
        exp_t e;
        int   acc;
        @(negedge clk);
        in_smp = x;
        in_vld = v;
        coef   = c;
        for (int k = NT - 1; k > 0; k--) begin
            xh[k] = xh[k-1];
            ch[k] = ch[k-1];
        end
        xh[0] = x;
        ch[0] = c;
        acc = 0;
        for (int k = 0; k < NT; k++) begin
            int xi, ci;
            xi = $signed(xh[k]);
            ci = $signed(ch[k][k*CW +: CW]);
            acc += xi * ci;
        end
        e.full = acc;
        e.vld  = v;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic apply_reset(input string tag);
        @(negedge clk);
        rst    = 1'b1;
        in_vld = 1'b0;
        in_smp = '0;
        sbq.delete();
        for (int k = 0; k < NT; k++) begin
            xh[k] = '0;
            ch[k] = '0;
        end
        repeat (2) @(negedge clk);
        check({tag, " wrap out_smp after reset"}, int'($signed(y_w)), 0);
        check({tag, " sat out_smp after reset"}, int'($signed(y_s)), 0);
        check({tag, " wrap out_vld after reset"}, int'(vld_w), 0);
        check({tag, " sat out_vld after reset"}, int'(vld_s), 0);
        rst = 1'b0;
    endtask

    // Monitor: pops one expected item per cycle once two are in flight
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() >= 2) begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, "/R5 wrap out_smp"}, int'($signed(y_w)), wrapv(e.full));
                check({e.tag, "/R6 sat out_smp"}, int'($signed(y_s)), clampv(e.full));
                check({e.tag, "/R3 out_vld"}, int'(vld_w), int'(e.vld));
                check({e.tag, "/R3 sat out_vld"}, int'(vld_s), int'(e.vld));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NT*CW-1:0] ca, cb;
        ca = pack_a();
        cb = pack_b();

        // R4: reset state
        apply_reset("R4 initial");

        // R2: impulse response appears two cycles after capture, tap order c0..c7
        step(6'd1, 1'b1, ca, "R2 impulse");
        for (int i = 0; i < 10; i++) step('0, 1'b0, ca, "R2 impulse tail");

        // R1: pseudo-random data, valid strobe toggling (R3)
        for (int i = 0; i < 40; i++) begin
            lfsr_next();
            step(lfsr[5:0], lfsr[9], ca, "R1 random");
        end

        // R7: extreme operands, large positive sum (wrap and saturate)
        for (int i = 0; i < 14; i++) step(6'h20, 1'b1, pack_all(-32), "R7 neg*neg");
        // R7: extreme operands, large negative sum
        for (int i = 0; i < 14; i++) step(6'h20, 1'b1, pack_all(31), "R7 neg*pos");
        // R7: mixed extremes
        for (int i = 0; i < 12; i++) step((i % 2) ? 6'h1F : 6'h20, 1'b1, pack_all(-32), "R7 alt");

        // R8: coefficient switches while partial sums are in flight
        for (int i = 0; i < 30; i++) begin
            lfsr_next();
            step(lfsr[5:0], 1'b1, ((i / 3) % 2) ? cb : ca, "R8 coef switch");
        end

        // R10: all coefficients zero with live data
        for (int i = 0; i < 14; i++) begin
            lfsr_next();
            step(lfsr[5:0], 1'b1, '0, "R10 zero coef");
        end

        // R4: reset in the middle of a nonzero stream
        for (int i = 0; i < 6; i++) begin
            lfsr_next();
            step(lfsr[5:0], 1'b1, cb, "R1 pre-reset");
        end
        apply_reset("R4 mid-stream");

        for (int i = 0; i < 10; i++) begin
            lfsr_next();
            step(lfsr[5:0], lfsr[3], cb, "R1 post-reset");
        end

        // R9: zero data flushes the chain
        for (int i = 0; i < 12; i++) step('0, 1'b0, cb, "R9 zero flush");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule